// File: doc/BRIEF.md
# Serial Frame Transmitter

This block turns one parallel character into an asynchronous serial frame on a single output line. The line rests high. A frame is a low start bit, then 5 to 9 data bits sent least significant bit first, then an optional parity bit of either sense, then one or two high stop bits. The character length, the parity use and sense, the stop count, the bit period and an optional synchronous mode are all chosen at run time. They are captured when a frame is launched, so later changes to those inputs affect only the next frame.

Software works one character at a time. It waits for the block to be idle, writes the character into the holding register and issues a start. It then waits for the busy flag to drop or for the one-cycle completion pulse before sending the next character. A bit period is `baud_div + 1` clock cycles and is produced by an internal divider that restarts at each launch. In synchronous mode a shift clock runs alongside the data. That clock is low in the first half of each bit period and high in the second half, so a receiver can sample on its rising edge.

Top module: `ser_frame_tx`

## Requirements
- R1: Out of reset and between frames, `txd` is 1 and `sclk`, `busy` and `done_irq` are 0.
- R2: A `start` seen while idle makes `busy` 1 from the next cycle on. `txd` then drives a 0 start bit for `baud_div + 1` cycles (`baud_div` of 1 or more).
- R3: Data bits follow the start bit, least significant bit (`data_in[0]`) first, each held for one bit period. The count is `cfg_len`, clamped to 5..9: values below 5 send 5 bits and values above 9 send 9.
- R4: With `cfg_par_en` = 1, one parity bit follows the data. With `cfg_par_odd` = 0 the total count of ones in the data bits plus the parity bit is even; with 1 it is odd. With `cfg_par_en` = 0 no parity bit is sent.
- R5: The frame ends with stop bits at 1: one stop bit when `cfg_two_stop` = 0, two when it is 1.
- R6: `busy` stays 1 until the last stop bit has been sent. `done_irq` is 1 for exactly one cycle, the first cycle after the final stop bit, and `busy` is 0 in that same cycle.
- R7: `start` and `data_wr` while `busy` is 1 have no effect. This includes the last cycle of the final stop bit. The running frame is unchanged, and a later start with no new write sends the character last written while idle.
- R8: When `data_wr` and `start` are both 1 in an idle cycle, the frame carries the newly written `data_in`.
- R9: With `cfg_sync` = 1 at launch, `sclk` is 0 for the first floor((`baud_div`+1)/2) cycles of each bit and 1 for the rest of the bit. With `cfg_sync` = 0, `sclk` stays 0.
- R10: `baud_div`, `cfg_len`, `cfg_par_en`, `cfg_par_odd`, `cfg_two_stop` and `cfg_sync` are captured at launch. Changing them during a frame leaves that frame unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_div | input | DIV_W | Bit period minus one, in clock cycles |
| cfg_len | input | LEN_W | Requested data bit count (clamped to 5..9) |
| cfg_par_en | input | 1 | 1 adds a parity bit |
| cfg_par_odd | input | 1 | Parity sense: 0 even, 1 odd |
| cfg_two_stop | input | 1 | 0 one stop bit, 1 two stop bits |
| cfg_sync | input | 1 | 1 drives the shift clock during the frame |
| data_wr | input | 1 | Holding register write strobe |
| data_in | input | MAX_BITS | Character to write |
| start | input | 1 | Launch a frame |
| txd | output | 1 | Serial data line, idle high |
| sclk | output | 1 | Shift clock in synchronous mode |
| busy | output | 1 | Frame in progress |
| done_irq | output | 1 | One-cycle completion pulse |

## Verification
The frame engine is driven with characters whose bit patterns differ at both ends: 0xA5, 0x13 (which has an odd count of ones), all ones, and 0x1E3 with a length request outside the legal range. Between them these tell apart bit order, the length clamp and parity sense. Each parity mode is paired with each stop count, and the runs use both an even and an odd bit period. This separates an off-by-one in the divider from a wrong shift-clock half point. Separate runs issue a write together with a start, write and start mid-frame and in the very last stop cycle, and change every format input during a frame. Each of these must leave the running frame exactly as a fresh reference frame predicts.

// File: rtl/stx_pkg.sv
package stx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } frame_st_e;

    // Force a requested length into the legal window [lo, hi].
    function automatic int unsigned clamp_len(int unsigned req, int unsigned lo, int unsigned hi);
        if (req < lo) return lo;
        if (req > hi) return hi;
        return req;
    endfunction

endpackage

// File: rtl/stx_baud_gen.sv
module stx_baud_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [DIV_W-1:0] div_in,
    output logic             bit_end,
    output logic             late_half
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] div;
    } baud_st_t;

    baud_st_t   r_q, r_d;
    logic [DIV_W:0] half_pt;

    assign bit_end   = run && (r_q.cnt == r_q.div);
    assign half_pt   = ({1'b0, r_q.div} + (DIV_W+1)'(1)) >> 1;
    assign late_half = run && ({1'b0, r_q.cnt} >= half_pt);

    always_comb begin
        r_d = r_q;
        if (restart) begin
            r_d.cnt = '0;
            r_d.div = div_in;
        end else if (!run || bit_end) begin
            r_d.cnt = '0;
        end else begin
            r_d.cnt = r_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

endmodule

// File: rtl/stx_parity.sv
module stx_parity #(
    parameter int MAX_BITS = 9,
    parameter int LEN_W    = 4
) (
    input  logic [MAX_BITS-1:0] data,
    input  logic [LEN_W-1:0]    len,
    input  logic                odd,
    output logic                par
);

    logic [MAX_BITS-1:0] keep;

    for (genvar i = 0; i < MAX_BITS; i++) begin : g_mask
        assign keep[i] = (i < int'(len));
    end

    assign par = (^(data & keep)) ^ odd;

endmodule

// File: rtl/stx_frame_ctrl.sv
module stx_frame_ctrl
    import stx_pkg::*;
#(
    parameter int MAX_BITS = 9,
    parameter int LEN_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                launch,
    input  logic [MAX_BITS-1:0] load_data,
    input  logic                load_par,
    input  logic [LEN_W-1:0]    len_in,
    input  logic                par_en_in,
    input  logic                two_stop_in,
    input  logic                sync_in,
    input  logic                bit_end,
    output logic                busy,
    output logic                txd,
    output logic                done_pulse,
    output logic                sync_mode
);

    typedef struct packed {
        frame_st_e           st;
        logic [MAX_BITS-1:0] shreg;
        logic [LEN_W-1:0]    idx;
        logic [LEN_W-1:0]    last_idx;
        logic                par_en;
        logic                par_bit;
        logic                two_stop;
        logic                stop2;
        logic                sync;
        logic                done;
    } ctrl_st_t;

    ctrl_st_t c_q, c_d;

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        unique case (c_q.st)
            ST_IDLE: begin
                if (launch) begin
                    c_d.st       = ST_START;
                    c_d.shreg    = load_data;
                    c_d.idx      = '0;
                    c_d.last_idx = len_in - LEN_W'(1);
                    c_d.par_en   = par_en_in;
                    c_d.par_bit  = load_par;
                    c_d.two_stop = two_stop_in;
                    c_d.stop2    = 1'b0;
                    c_d.sync     = sync_in;
                end
            end
            ST_START: begin
                if (bit_end) c_d.st = ST_DATA;
            end
            ST_DATA: begin
                if (bit_end) begin
                    c_d.shreg = c_q.shreg >> 1;
                    if (c_q.idx == c_q.last_idx) begin
                        c_d.st = c_q.par_en ? ST_PAR : ST_STOP;
                    end else begin
                        c_d.idx = c_q.idx + LEN_W'(1);
                    end
                end
            end
            ST_PAR: begin
                if (bit_end) c_d.st = ST_STOP;
            end
            ST_STOP: begin
                if (bit_end) begin
                    if (c_q.two_stop && !c_q.stop2) begin
                        c_d.stop2 = 1'b1;
                    end else begin
                        c_d.st   = ST_IDLE;
                        c_d.done = 1'b1;
                    end
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q    <= '0;
            c_q.st <= ST_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    always_comb begin
        unique case (c_q.st)
            ST_START: txd = 1'b0;
            ST_DATA:  txd = c_q.shreg[0];
            ST_PAR:   txd = c_q.par_bit;
            default:  txd = 1'b1;
        endcase
    end

    assign busy       = (c_q.st != ST_IDLE);
    assign done_pulse = c_q.done;
    assign sync_mode  = c_q.sync;

endmodule

// File: rtl/ser_frame_tx.sv
module ser_frame_tx
    import stx_pkg::*;
#(
    parameter  int MAX_BITS = 9,
    parameter  int MIN_BITS = 5,
    parameter  int DIV_W    = 16,
    localparam int LEN_W    = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DIV_W-1:0]    baud_div,
    input  logic [LEN_W-1:0]    cfg_len,
    input  logic                cfg_par_en,
    input  logic                cfg_par_odd,
    input  logic                cfg_two_stop,
    input  logic                cfg_sync,
    input  logic                data_wr,
    input  logic [MAX_BITS-1:0] data_in,
    input  logic                start,
    output logic                txd,
    output logic                sclk,
    output logic                busy,
    output logic                done_irq
);

    typedef struct packed {
        logic [MAX_BITS-1:0] hold;
    } top_st_t;

    top_st_t t_q, t_d;

    logic                busy_w;
    logic                launch;
    logic [MAX_BITS-1:0] launch_data;
    logic [LEN_W-1:0]    len_eff;
    logic                par_w;
    logic                bit_tick;
    logic                late_half;
    logic                sync_mode;

    assign launch      = start && !busy_w;
    assign launch_data = data_wr ? data_in : t_q.hold;
    assign len_eff     = LEN_W'(clamp_len(int'(cfg_len), MIN_BITS, MAX_BITS));

    always_comb begin
        t_d = t_q;
        if (data_wr && !busy_w) t_d.hold = data_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    stx_baud_gen #(
        .DIV_W (DIV_W)
    ) u_baud (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (launch),
        .run       (busy_w),
        .div_in    (baud_div),
        .bit_end   (bit_tick),
        .late_half (late_half)
    );

    stx_parity #(
        .MAX_BITS (MAX_BITS),
        .LEN_W    (LEN_W)
    ) u_par (
        .data (launch_data),
        .len  (len_eff),
        .odd  (cfg_par_odd),
        .par  (par_w)
    );

    stx_frame_ctrl #(
        .MAX_BITS (MAX_BITS),
        .LEN_W    (LEN_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch      (launch),
        .load_data   (launch_data),
        .load_par    (par_w),
        .len_in      (len_eff),
        .par_en_in   (cfg_par_en),
        .two_stop_in (cfg_two_stop),
        .sync_in     (cfg_sync),
        .bit_end     (bit_tick),
        .busy        (busy_w),
        .txd         (txd),
        .done_pulse  (done_irq),
        .sync_mode   (sync_mode)
    );

    assign busy = busy_w;
    assign sclk = sync_mode && late_half;

endmodule

// File: rtl/stx_checker.sv
module stx_checker (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic txd,
    input logic sclk,
    input logic done_irq,
    input logic bit_tick
);

    p_idle_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (txd && !sclk));

    p_start_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !txd));

    p_bit_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !bit_tick) |=> (busy && $stable(txd)));

    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |=> !done_irq);

    p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> !busy);

    p_end_signalled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done_irq);

    p_sclk_in_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> busy);

endmodule

bind ser_frame_tx stx_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .txd      (txd),
    .sclk     (sclk),
    .done_irq (done_irq),
    .bit_tick (bit_tick)
);

// File: tb/ser_frame_tx_bench.sv
module ser_frame_tx_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] baud_div = 16'd3;
    logic [3:0]  cfg_len = 4'd8;
    logic        cfg_par_en = 1'b0;
    logic        cfg_par_odd = 1'b0;
    logic        cfg_two_stop = 1'b0;
    logic        cfg_sync = 1'b0;
    logic        data_wr = 1'b0;
    logic [8:0]  data_in = '0;
    logic        start = 1'b0;
    logic        txd, sclk, busy, done_irq;

    always #4 clk = ~clk;

    ser_frame_tx u_ser_frame_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .baud_div     (baud_div),
        .cfg_len      (cfg_len),
        .cfg_par_en   (cfg_par_en),
        .cfg_par_odd  (cfg_par_odd),
        .cfg_two_stop (cfg_two_stop),
        .cfg_sync     (cfg_sync),
        .data_wr      (data_wr),
        .data_in      (data_in),
        .start        (start),
        .txd          (txd),
        .sclk         (sclk),
        .busy         (busy),
        .done_irq     (done_irq)
    );

    int    checks = 0;
    int    fails  = 0;
    int    cycles = 0;
    string scen   = "R1";

    // Reference model: one queue entry per clock cycle of the frame.
    bit    q_txd[$];
    bit    q_sclk[$];
    string q_tag[$];
    logic [8:0] m_hold = '0;
    bit    exp_done = 1'b0;

    task automatic push_bit(input bit v, input string field, input int p, input bit syn);
        for (int k = 0; k < p; k++) begin
            q_txd.push_back(v);
            q_sclk.push_back(syn && (k >= p / 2));
            q_tag.push_back({field, " [", scen, "]"});
        end
    endtask

    task automatic push_frame(input logic [8:0] d);
        int p;
        int n;
        int ones;
        p    = int'(baud_div) + 1;
        n    = int'(cfg_len);
        if (n < 5) n = 5;
        if (n > 9) n = 9;
        ones = 0;
        push_bit(1'b0, "R2 start", p, cfg_sync);
        for (int i = 0; i < n; i++) begin
            push_bit(d[i], "R3 data", p, cfg_sync);
            if (d[i]) ones++;
        end
        if (cfg_par_en) push_bit(((ones % 2) == 1) ^ cfg_par_odd, "R4 parity", p, cfg_sync);
        push_bit(1'b1, "R5 stop", p, cfg_sync);
        if (cfg_two_stop) push_bit(1'b1, "R5 stop2", p, cfg_sync);
    endtask

    always @(posedge clk) begin
        bit was_busy;
        if (!rst_n) begin
            q_txd.delete();
            q_sclk.delete();
            q_tag.delete();
            m_hold   = '0;
            exp_done = 1'b0;
        end else begin
            was_busy = (q_txd.size() != 0);
            if (was_busy) begin
                void'(q_txd.pop_front());
                void'(q_sclk.pop_front());
                void'(q_tag.pop_front());
            end
            exp_done = was_busy && (q_txd.size() == 0);
            if (start && !was_busy) push_frame(data_wr ? data_in : m_hold);
            if (data_wr && !was_busy) m_hold = data_in;
        end
    end

    task automatic chk(input logic act, input logic exp, input string tag, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (q_txd.size() != 0) begin
            chk(txd, q_txd[0], q_tag[0], "txd");
            chk(sclk, q_sclk[0], {"R9 ", q_tag[0]}, "sclk");
            chk(busy, 1'b1, {"R6 ", q_tag[0]}, "busy");
        end else begin
            chk(txd, 1'b1, {"R1 idle [", scen, "]"}, "txd");
            chk(sclk, 1'b0, {"R1 idle [", scen, "]"}, "sclk");
            chk(busy, 1'b0, {"R6 idle [", scen, "]"}, "busy");
        end
        chk(done_irq, exp_done, {"R6 done [", scen, "]"}, "done_irq");
    end

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 100000", cycles);
            finish_run();
        end
    end

    task automatic step;
        @(posedge clk);
        #1;
    endtask

    task automatic write_data(input logic [8:0] d);
        data_wr = 1'b1;
        data_in = d;
        step();
        data_wr = 1'b0;
    endtask

    task automatic launch;
        start = 1'b1;
        step();
        start = 1'b0;
    endtask

    task automatic wait_idle;
        do step(); while (q_txd.size() != 0);
        repeat (3) step();
    endtask

    task automatic set_fmt(input int div, input int len, input bit pe, input bit po,
                           input bit ts, input bit sy);
        baud_div     = 16'(div);
        cfg_len      = 4'(len);
        cfg_par_en   = pe;
        cfg_par_odd  = po;
        cfg_two_stop = ts;
        cfg_sync     = sy;
    endtask

    initial begin
        scen = "R1 reset";
        repeat (5) step();
        rst_n = 1'b1;
        repeat (4) step();

        scen = "R3 len8 plain";
        set_fmt(3, 8, 0, 0, 0, 0);
        write_data(9'h0A5);
        step();
        launch();
        wait_idle();

        scen = "R4 len5 even";
        set_fmt(3, 5, 1, 0, 0, 0);
        write_data(9'h013);
        launch();
        wait_idle();

        scen = "R5 len9 odd two-stop";
        set_fmt(4, 9, 1, 1, 1, 0);
        write_data(9'h1FF);
        launch();
        wait_idle();

        scen = "R4 len7 odd";
        set_fmt(2, 7, 1, 1, 0, 0);
        write_data(9'h013);
        launch();
        wait_idle();

        scen = "R3 clamp low";
        set_fmt(2, 4, 0, 0, 0, 0);
        write_data(9'h1E3);
        launch();
        wait_idle();

        scen = "R3 clamp high";
        set_fmt(2, 15, 1, 0, 1, 0);
        launch();
        wait_idle();

        scen = "R9 sync odd period";
        set_fmt(4, 7, 1, 1, 0, 1);
        write_data(9'h05A);
        launch();
        wait_idle();

        scen = "R9 sync even period";
        set_fmt(1, 6, 0, 0, 1, 1);
        write_data(9'h02C);
        launch();
        wait_idle();

        scen = "R8 write with start";
        set_fmt(3, 8, 1, 0, 0, 0);
        data_wr = 1'b1;
        data_in = 9'h0C3;
        start   = 1'b1;
        step();
        data_wr = 1'b0;
        start   = 1'b0;
        wait_idle();

        scen = "R7 R10 busy ignores";
        set_fmt(3, 8, 0, 0, 0, 0);
        write_data(9'h055);
        launch();
        repeat (9) step();
        data_wr = 1'b1;
        data_in = 9'h10F;
        start   = 1'b1;
        set_fmt(1, 5, 1, 1, 1, 1);
        step();
        data_wr = 1'b0;
        start   = 1'b0;
        repeat (7) step();
        set_fmt(6, 9, 1, 0, 0, 1);
        do step(); while (q_txd.size() != 1);
        start   = 1'b1;
        data_wr = 1'b1;
        data_in = 9'h1AA;
        step();
        start   = 1'b0;
        data_wr = 1'b0;
        wait_idle();

        scen = "R7 held data resent";
        set_fmt(3, 8, 0, 0, 0, 0);
        launch();
        wait_idle();

        finish_run();
    end

endmodule